// File: doc/BRIEF.md
# Pointer-Window Data Memory

This block is the data store of a small 8-bit controller. The 8-bit address space holds general RAM from address 0 up, its size set by a parameter to 64 or 128 bytes. The top sixteen addresses, 0xF0 to 0xFF, form a window of register bytes. Three of those bytes hold the RAM pointers: the alternate pointer at 0xFC, the stack pointer at 0xFD and the base pointer at 0xFE. Addresses between the end of RAM and 0xEF are unmapped.

One command enters per clock on a flat operand port. A direct command names the address itself. An indirect command uses the alternate or the base pointer as the address and may then step that pointer up or down. Other commands load an immediate value into the window, decrement a window byte and report when the result is zero, or set, clear or test one bit of any byte. Writes take effect at the clock edge that accepts the command. Read data and the two flags are registered and are valid in the cycle after that edge.

Top module: `ptr_window_mem`

## Requirements
- R1: Command codes are 0 no-op, 1 direct read, 2 direct write, 3 indirect read, 4 indirect write, 5 immediate load, 6 decrement-and-test, 7 bit set, 8 bit clear and 9 bit test. The codes 10 to 15 act as no-ops. `rdData` takes the value of the byte read by a direct or indirect read in the cycle after the command. A write is visible to a read issued in the next cycle.
- R2: During and after reset the stack pointer at 0xFD holds RAM_BYTES-17, which is 0x2F for 64 bytes and 0x6F for 128 bytes. Every other byte and all outputs are zero.
- R3: The alternate pointer (0xFC), the stack pointer (0xFD) and the base pointer (0xFE) can be read and written by direct access like any byte. 0xFF is an ordinary storage byte.
- R4: An immediate load writes `wrData` to an address from 0xF0 to 0xFE. At any other address it changes nothing.
- R5: An indirect read or write accesses the byte whose address is the value of the alternate pointer (`ptrSel`=0) or of the base pointer (`ptrSel`=1).
- R6: After an indirect access, `ptrMode` 1 adds one to the pointer used and `ptrMode` 2 subtracts one. Modes 0 and 3 leave the pointer unchanged. Stepping wraps modulo 256.
- R7: When an indirect write targets the pointer it uses, the written value is stored first and the step is then applied to that stored value.
- R8: Decrement-and-test on an address from 0xF0 to 0xFE stores the byte minus one, wrapping from 0 to 0xFF. In the next cycle `rdData` shows the result and `skipFlag` is 1 exactly when the result is zero. At other addresses nothing is stored and `skipFlag` stays 0.
- R9: Bit set and bit clear change only bit `bitIdx` of the byte at `addr` and work on any mapped byte.
- R10: After a bit test, `bitFlag` equals bit `bitIdx` of the byte at `addr` for one cycle. `bitFlag` and `skipFlag` are 0 after any other command.
- R11: Addresses from RAM_BYTES to 0xEF read as zero and ignore every kind of write.
- R12: With `opValid` low, no byte changes and `rdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Command present this cycle |
| opCode | input | 4 | Command code (see R1) |
| addr | input | 8 | Direct address |
| wrData | input | 8 | Write or immediate data |
| ptrSel | input | 1 | Indirect pointer: 0 alternate, 1 base |
| ptrMode | input | 2 | Pointer step after indirect access |
| bitIdx | input | 3 | Bit selected for bit commands |
| rdData | output | 8 | Registered read or decrement result |
| skipFlag | output | 1 | Registered zero result of decrement-and-test |
| bitFlag | output | 1 | Registered bit-test result |

## Verification
A wrong pointer value does not show at the ports until an indirect access uses it. The next indirect read then returns the byte at the wrong address, one cycle later. A write through a bad pointer is hidden until that location or its intended target is read, which can be many commands later. For this reason the bench compares every read and flag against a model of all 256 addresses, and it ends with a sweep that reads every address directly, so that a wrong byte anywhere shows up.

// File: rtl/ptr_window_pkg.sv
package ptr_window_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_RD   = 4'd1,
    CMD_WR   = 4'd2,
    CMD_IRD  = 4'd3,
    CMD_IWR  = 4'd4,
    CMD_LDI  = 4'd5,
    CMD_DSZ  = 4'd6,
    CMD_SETB = 4'd7,
    CMD_CLRB = 4'd8,
    CMD_TSTB = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    WK_DATA = 2'd0,
    WK_DEC  = 2'd1,
    WK_SET  = 2'd2,
    WK_CLR  = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic     indirect;
    logic     ptrIsB;
    logic     ptrUpd;
    logic     ptrDec;
    logic     doWrite;
    wr_kind_e wrKind;
    logic     loadRd;
    logic     rdResult;
    logic     loadSkip;
    logic     loadBit;
  } strobe_t;

  localparam logic [3:0] SLOT_X  = 4'hC;
  localparam logic [3:0] SLOT_SP = 4'hD;
  localparam logic [3:0] SLOT_B  = 4'hE;

endpackage

// File: rtl/ptr_window_ctrl.sv
module ptr_window_ctrl
  import ptr_window_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic [7:0] addr,
  input  logic       ptrSel,
  input  logic [1:0] ptrMode,
  output strobe_t    st
);

  logic inWindow;
  logic stepOn;
  cmd_e cmd;

  assign inWindow = (addr[7:4] == 4'hF) && (addr[3:0] != 4'hF);
  assign stepOn   = (ptrMode == 2'd1) || (ptrMode == 2'd2);
  assign cmd      = cmd_e'(opCode);

  always_comb begin
    st = '0;
    if (opValid) begin
      unique case (cmd)
        CMD_RD: begin
          st.loadRd = 1'b1;
        end
        CMD_WR: begin
          st.doWrite = 1'b1;
          st.wrKind  = WK_DATA;
        end
        CMD_IRD, CMD_IWR: begin
          st.indirect = 1'b1;
          st.ptrIsB   = ptrSel;
          st.ptrUpd   = stepOn;
          st.ptrDec   = (ptrMode == 2'd2);
          st.loadRd   = (cmd == CMD_IRD);
          st.doWrite  = (cmd == CMD_IWR);
          st.wrKind   = WK_DATA;
        end
        CMD_LDI: begin
          st.doWrite = inWindow;
          st.wrKind  = WK_DATA;
        end
        CMD_DSZ: begin
          st.doWrite  = inWindow;
          st.wrKind   = WK_DEC;
          st.loadRd   = inWindow;
          st.rdResult = 1'b1;
          st.loadSkip = inWindow;
        end
        CMD_SETB: begin
          st.doWrite = 1'b1;
          st.wrKind  = WK_SET;
        end
        CMD_CLRB: begin
          st.doWrite = 1'b1;
          st.wrKind  = WK_CLR;
        end
        CMD_TSTB: begin
          st.loadBit = 1'b1;
        end
        default: st = '0;
      endcase
    end
  end

endmodule

// File: rtl/ptr_window_datapath.sv
module ptr_window_datapath
  import ptr_window_pkg::*;
#(
  parameter int RAM_BYTES = 64
)(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  logic [2:0] bitIdx,
  output logic [7:0] rdData,
  output logic       skipFlag,
  output logic       bitFlag
);

  localparam int         RAM_AW   = $clog2(RAM_BYTES);
  localparam logic [8:0] RAM_TOP  = 9'(RAM_BYTES);
  localparam logic [7:0] SP_RESET = 8'(RAM_BYTES - 17);
  localparam int         WIN_SLOTS = 16;

  logic [7:0] ramQ [RAM_BYTES];
  logic [7:0] winQ [WIN_SLOTS];

  logic [3:0] ptrIdx;
  logic [7:0] curPtr;
  logic [7:0] effAddr;
  logic       isRam;
  logic       isWin;
  logic [7:0] curByte;
  logic [7:0] bitMask;
  logic [7:0] wrVal;
  logic       wrRam;
  logic       wrWin;
  logic       selfHit;
  logic [7:0] ptrBase;
  logic [7:0] ptrNext;

  assign ptrIdx  = st.ptrIsB ? SLOT_B : SLOT_X;
  assign curPtr  = winQ[ptrIdx];
  assign effAddr = st.indirect ? curPtr : addr;
  assign isRam   = {1'b0, effAddr} < RAM_TOP;
  assign isWin   = effAddr[7:4] == 4'hF;
  assign bitMask = 8'(8'd1 << bitIdx);

  always_comb begin
    if (isRam)      curByte = ramQ[effAddr[RAM_AW-1:0]];
    else if (isWin) curByte = winQ[effAddr[3:0]];
    else            curByte = 8'h00;
  end

  always_comb begin
    unique case (st.wrKind)
      WK_DATA: wrVal = wrData;
      WK_DEC:  wrVal = curByte - 8'd1;
      WK_SET:  wrVal = curByte | bitMask;
      WK_CLR:  wrVal = curByte & ~bitMask;
      default: wrVal = wrData;
    endcase
  end

  assign wrRam   = st.doWrite && isRam;
  assign wrWin   = st.doWrite && isWin;
  assign selfHit = wrWin && (effAddr[3:0] == ptrIdx);
  assign ptrBase = selfHit ? wrVal : curPtr;
  assign ptrNext = st.ptrDec ? ptrBase - 8'd1 : ptrBase + 8'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_BYTES; i++) ramQ[i] <= 8'h00;
    end else if (wrRam) begin
      ramQ[effAddr[RAM_AW-1:0]] <= wrVal;
    end
  end

  for (genvar s = 0; s < WIN_SLOTS; s++) begin : g_slot
    localparam logic [7:0] INIT = (s == int'(SP_SLOT_IDX())) ? SP_RESET : 8'h00;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        winQ[s] <= INIT;
      end else begin
        if (wrWin && (effAddr[3:0] == 4'(s))) winQ[s] <= wrVal;
        if (st.ptrUpd && (ptrIdx == 4'(s)))   winQ[s] <= ptrNext;
      end
    end
  end

  function automatic int SP_SLOT_IDX();
    return int'(SLOT_SP);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= 8'h00;
      skipFlag <= 1'b0;
      bitFlag  <= 1'b0;
    end else begin
      if (st.loadRd) rdData <= st.rdResult ? wrVal : curByte;
      skipFlag <= st.loadSkip && (wrVal == 8'h00);
      bitFlag  <= st.loadBit && ((curByte & bitMask) != 8'h00);
    end
  end

  // Stack pointer leaves reset at its size-dependent value
  assert_sp_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> winQ[SLOT_SP] == SP_RESET);

  // Plain post-increment and post-decrement step from the old pointer
  assert_ptr_inc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.ptrUpd && !st.ptrDec && !selfHit) |=>
      winQ[$past(ptrIdx)] == 8'($past(curPtr) + 8'd1));

  assert_ptr_dec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.ptrUpd && st.ptrDec && !selfHit) |=>
      winQ[$past(ptrIdx)] == 8'($past(curPtr) - 8'd1));

  // Self-targeted indirect write steps the freshly stored value
  assert_self_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.ptrUpd && selfHit && !st.ptrDec) |=>
      winQ[$past(ptrIdx)] == 8'($past(wrData) + 8'd1));

  // A skip always reports a zero result
  assert_skip_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    skipFlag |-> rdData == 8'h00);

  // Unmapped addresses read back as zero
  assert_hole_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadRd && !st.rdResult && !isRam && !isWin) |=> rdData == 8'h00);

  // Idle cycles keep the read register
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (st == '0) |=> $stable(rdData));

endmodule

// File: rtl/ptr_window_mem.sv
module ptr_window_mem
  import ptr_window_pkg::*;
#(
  parameter int RAM_BYTES = 64
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  logic       ptrSel,
  input  logic [1:0] ptrMode,
  input  logic [2:0] bitIdx,
  output logic [7:0] rdData,
  output logic       skipFlag,
  output logic       bitFlag
);

  strobe_t st;

  ptr_window_ctrl i_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .addr    (addr),
    .ptrSel  (ptrSel),
    .ptrMode (ptrMode),
    .st      (st)
  );

  ptr_window_datapath #(.RAM_BYTES(RAM_BYTES)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .addr     (addr),
    .wrData   (wrData),
    .bitIdx   (bitIdx),
    .rdData   (rdData),
    .skipFlag (skipFlag),
    .bitFlag  (bitFlag)
  );

endmodule

// File: tb/test_ptr_window_mem.sv
module test_ptr_window_mem;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int RAMB = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] addr = 8'd0;
  logic [7:0] wrData = 8'd0;
  logic       ptrSel = 1'b0;
  logic [1:0] ptrMode = 2'd0;
  logic [2:0] bitIdx = 3'd0;
  logic [7:0] rdData;
  logic       skipFlag;
  logic       bitFlag;

  int checks = 0;
  int failures = 0;
  logic [7:0] m [256];
  logic [7:0] expRd = 8'h00;

  always #2.5 clk = ~clk;

  ptr_window_mem #(.RAM_BYTES(RAMB)) i_ptr_window_mem (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .addr(addr),
    .wrData(wrData), .ptrSel(ptrSel), .ptrMode(ptrMode), .bitIdx(bitIdx),
    .rdData(rdData), .skipFlag(skipFlag), .bitFlag(bitFlag)
  );

  function automatic bit mapped(input logic [7:0] a);
    return (int'(a) < RAMB) || (a >= 8'hF0);
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] a);
    return mapped(a) ? m[a] : 8'h00;
  endfunction

  function automatic string tagFor(input logic [3:0] op, input logic [7:0] a);
    if (!mapped(a)) return "R11";
    case (op)
      4'd1, 4'd2: return (a >= 8'hFC) ? "R3" : "R1";
      4'd3, 4'd4: return "R5";
      4'd5: return "R4";
      4'd6: return "R8";
      4'd7, 4'd8: return "R9";
      4'd9: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic v, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] wd, input logic ps, input logic [1:0] pm,
                       input logic [2:0] bi);
    logic [7:0] pa, ea, val;
    logic expSkip, expBit;
    string tag;
    bit doRd;
    opValid = v; opCode = op; addr = a; wrData = wd;
    ptrSel = ps; ptrMode = pm; bitIdx = bi;
    expSkip = 1'b0; expBit = 1'b0; doRd = 1'b0;
    pa = ps ? 8'hFE : 8'hFC;
    ea = a;
    tag = v ? tagFor(op, a) : "R12";
    if (v) begin
      case (op)
        4'd1: begin expRd = mread(a); doRd = 1; end
        4'd2: if (mapped(a)) m[a] = wd;
        4'd3, 4'd4: begin
          ea = m[pa];
          tag = mapped(ea) ? "R5" : "R11";
          if (op == 4'd3) begin expRd = mread(ea); doRd = 1; end
          else if (mapped(ea)) m[ea] = wd;
          if (pm == 2'd1) m[pa] = m[pa] + 8'd1;
          if (pm == 2'd2) m[pa] = m[pa] - 8'd1;
        end
        4'd5: if (a >= 8'hF0 && a != 8'hFF) m[a] = wd;
        4'd6: if (a >= 8'hF0 && a != 8'hFF) begin
          val = m[a] - 8'd1; m[a] = val; expRd = val; expSkip = (val == 8'h00); doRd = 1;
        end
        4'd7: if (mapped(a)) m[a] = m[a] | 8'(8'd1 << bi);
        4'd8: if (mapped(a)) m[a] = m[a] & ~8'(8'd1 << bi);
        4'd9: expBit = mread(a)[bi];
        default: ;
      endcase
    end
    @(negedge clk);
    if (doRd || !v) chk(tag, rdData, expRd);
    chk((op == 4'd6) ? "R8" : "R10", {7'd0, skipFlag}, {7'd0, expSkip});
    chk("R10", {7'd0, bitFlag}, {7'd0, expBit});
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m[8'hFD] = 8'(RAMB - 17);
    repeat (3) @(negedge clk);
    // R2: outputs zero in reset
    chk("R2", rdData, 8'h00);
    chk("R2", {6'd0, skipFlag, bitFlag}, 8'h00);
    rstN = 1'b1;
    // R2: stack pointer value after reset
    runOp(1, 4'd1, 8'hFD, 0, 0, 0, 0);
    chk("R2", rdData, 8'h2F);
    runOp(1, 4'd1, 8'hFC, 0, 0, 0, 0);
    // R1 / R3: direct write and readback, pointers and 0xFF
    runOp(1, 4'd2, 8'h05, 8'hA5, 0, 0, 0);
    runOp(1, 4'd1, 8'h05, 0, 0, 0, 0);
    runOp(1, 4'd2, 8'hFF, 8'h3C, 0, 0, 0);
    runOp(1, 4'd1, 8'hFF, 0, 0, 0, 0);
    // R5 / R6: indirect via X with increment, wrap at 0xFF
    runOp(1, 4'd2, 8'hFC, 8'hFF, 0, 0, 0);
    runOp(1, 4'd3, 8'h00, 0, 0, 2'd1, 0);
    runOp(1, 4'd1, 8'hFC, 0, 0, 0, 0);
    chk("R6", rdData, 8'h00);
    // R6: B decrement wraps from 0x00 to 0xFF
    runOp(1, 4'd2, 8'hFE, 8'h00, 0, 0, 0);
    runOp(1, 4'd4, 8'h00, 8'h77, 1, 2'd2, 0);
    runOp(1, 4'd1, 8'hFE, 0, 0, 0, 0);
    chk("R6", rdData, 8'hFF);
    runOp(1, 4'd1, 8'h00, 0, 0, 0, 0);
    // R7: indirect write to X through X with increment
    runOp(1, 4'd2, 8'hFC, 8'hFC, 0, 0, 0);
    runOp(1, 4'd4, 8'h00, 8'h40, 0, 2'd1, 0);
    runOp(1, 4'd1, 8'hFC, 0, 0, 0, 0);
    chk("R7", rdData, 8'h41);
    // R4: immediate load in and out of the window
    runOp(1, 4'd5, 8'hF3, 8'h01, 0, 0, 0);
    runOp(1, 4'd5, 8'h10, 8'h99, 0, 0, 0);
    runOp(1, 4'd1, 8'h10, 0, 0, 0, 0);
    // R8: decrement to zero raises skip, then wraps
    runOp(1, 4'd6, 8'hF3, 0, 0, 0, 0);
    runOp(1, 4'd6, 8'hF3, 0, 0, 0, 0);
    runOp(1, 4'd6, 8'h08, 0, 0, 0, 0);
    // R9 / R10: bit ops
    runOp(1, 4'd7, 8'h20, 0, 0, 0, 3'd7);
    runOp(1, 4'd9, 8'h20, 0, 0, 0, 3'd7);
    runOp(1, 4'd8, 8'h20, 0, 0, 0, 3'd7);
    runOp(1, 4'd9, 8'h20, 0, 0, 0, 3'd7);
    // R11: hole ignores writes and bit sets
    runOp(1, 4'd2, 8'h80, 8'hEE, 0, 0, 0);
    runOp(1, 4'd7, 8'h80, 0, 0, 0, 3'd0);
    runOp(1, 4'd1, 8'h80, 0, 0, 0, 0);
    // R12: idle cycles with write-like codes
    runOp(0, 4'd2, 8'h05, 8'h11, 0, 0, 0);
    runOp(1, 4'd1, 8'h05, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      case ($urandom % 4)
        0: a = 8'($urandom % RAMB);
        1: a = 8'hF0 | 8'($urandom % 16);
        2: a = 8'($urandom);
        default: a = 8'hFC + 8'($urandom % 3);
      endcase
      runOp(($urandom % 8) != 0, 4'($urandom % 11), a, 8'($urandom),
            1'($urandom), 2'($urandom), 3'($urandom));
    end
    // sweep every address
    for (int a = 0; a < 256; a++) runOp(1, 4'd1, 8'(a), 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule